// File: doc/BRIEF.md
# Byte-Enable Bus Address Adapter

This block connects a 32-bit processor-style bus, which presents a word address and four active-low lane enables, to a system bus that needs a full byte address. When a bus cycle starts, the adapter captures the word address, the lane enables and the memory/IO indication. It then rebuilds the two low address bits from the lowest-numbered active lane. It reports which data byte lanes take part and classifies I/O cycles by address space.

The address-space decode asserts a coprocessor chip select for I/O cycles with the top address bit set. It flags I/O cycles inside the 64 KiB programmed I/O space. It raises an error for I/O cycles that fall in neither window. A bus-state timer tracks each cycle from the strobe to the ready response. It reports the end of the cycle and the number of wait states.

There is no streaming data path, so all pins are plain level or pulse signals. There is no valid/ready handshake. The address strobe and the ready input are the only flow control. A strobe that arrives while a cycle is in progress is not accepted.

Top module: `bus_cycle_adapter`

## Requirements
- R1: `lane_mask[i]` is the inverse of `lane_en_n[i]` as captured at the start of the cycle. Bit i marks data bits 8i+7 down to 8i.
- R2: `phys_addr[1:0]` is set by the lowest-numbered active (low) enable. Lane 0 gives 00, lane 1 gives 01, lane 2 gives 10, and lane 3 (when it is the only active lane) gives 11.
- R3: If no enable is low, `no_lane_err` is 1 and `phys_addr[1:0]` is 00. Otherwise `no_lane_err` is 0.
- R4: `phys_addr[31:2]` equals the captured `word_addr`, unchanged.
- R5: `pio_hit` is 1 only for an I/O cycle (`mem_sel`=0) whose byte address is at most 0000FFFFh.
- R6: `cop_cs` is 1 for an I/O cycle with address bit 31 set, for example 800000F8h to 800000FFh. No other address bit is used in this decode.
- R7: `io_range_err` is 1 for an I/O cycle that is neither a programmed I/O hit nor a coprocessor cycle. A memory cycle (`mem_sel`=1, shown on `is_mem`) sets none of `pio_hit`, `cop_cs` or `io_range_err`.
- R8: The decoded outputs are registered on the clock edge where `strb_n` is sampled low while idle, and `busy` rises at that edge. The outputs keep their values while `busy` is 1. Input changes and new strobes during that time have no effect.
- R9: A cycle lasts at least two bus states. It ends at the first edge after the strobe edge where `rdy_n` is sampled low. At that edge `busy` falls and `cyc_done` pulses high for exactly one clock. `rdy_n` sampled at the strobe edge itself is ignored.
- R10: At the end of a cycle, `wait_cnt` equals the number of states beyond two, i.e. the number of edges where `rdy_n` was sampled high while busy. It saturates at 2^WAIT_W-1 and holds its value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus state per period |
| rst_n | input | 1 | Active-low synchronous reset |
| strb_n | input | 1 | Active-low address strobe, starts a cycle |
| rdy_n | input | 1 | Active-low ready, ends a cycle |
| word_addr | input | 30 | Word address, bits 31:2 |
| lane_en_n | input | 4 | Active-low byte lane enables |
| mem_sel | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| phys_addr | output | 32 | Rebuilt byte base address |
| lane_mask | output | 4 | Active-high participating lanes |
| no_lane_err | output | 1 | No lane enabled in this cycle |
| is_mem | output | 1 | Captured memory/IO indication |
| pio_hit | output | 1 | I/O cycle in programmed I/O space |
| cop_cs | output | 1 | Coprocessor chip select |
| io_range_err | output | 1 | I/O cycle outside both windows |
| busy | output | 1 | Cycle in progress |
| cyc_done | output | 1 | One-clock pulse at cycle end |
| wait_cnt | output | WAIT_W | Wait states of the current or last cycle |

## Verification
The bench runs all sixteen lane-enable patterns, including the case with no lane and the case with only lane 3. A priority taken from the highest lane, or a missing error case, would show wrong low bits. I/O addresses are placed just below and just above the programmed I/O limit, at the coprocessor window, and at a high address that is not I/O. A comparison one bit too wide, or a window decoded from more than bit 31, would misflag one of these. The bench checks cycles with zero, one and several wait states, and one with more waits than the counter holds. It holds ready low during the strobe state to catch a cycle that ends one state early. It changes the inputs and strobes again in mid-cycle to catch outputs that are not held.

// File: rtl/bca_pkg.sv
package bca_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_ACTIVE = 1'b1} cyc_state_t;

  typedef struct packed {
    logic pio;
    logic cop;
    logic oor;
  } space_t;
endpackage

// File: rtl/lane_decode.sv
module lane_decode #(
  parameter int LANES = 4,
  localparam int LOW_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] en_n,
  output logic [LANES-1:0] mask,
  output logic [LOW_W-1:0] low,
  output logic             none
);
  assign mask = ~en_n;
  assign none = &en_n;

  // lowest active lane wins: scan from the top so lower lanes overwrite
  always_comb begin
    low = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (!en_n[i]) low = LOW_W'(i);
    end
  end
endmodule

// File: rtl/space_decode.sv
module space_decode
  import bca_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PIO_W  = 16
) (
  input  logic [ADDR_W-1:2] wa,
  input  logic              mem,
  output space_t            sp
);
  logic pio_zone;
  assign pio_zone = (wa[ADDR_W-1:PIO_W] == '0);

  always_comb begin
    sp.pio = !mem && pio_zone;
    sp.cop = !mem && wa[ADDR_W-1];
    sp.oor = !mem && !pio_zone && !wa[ADDR_W-1];
  end
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import bca_pkg::*;
#(
  parameter int WAIT_W = 6,
  localparam logic [WAIT_W-1:0] WAIT_MAX = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_n,
  input  logic              rdy_n,
  output logic              start,
  output logic              busy,
  output logic              done,
  output logic [WAIT_W-1:0] wait_cnt
);
  cyc_state_t state;

  assign busy  = (state == ST_ACTIVE);
  assign start = (state == ST_IDLE) && !strb_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      wait_cnt <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_ACTIVE;
          wait_cnt <= '0;
        end
        ST_ACTIVE: if (!rdy_n) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else if (wait_cnt != WAIT_MAX) begin
          wait_cnt <= wait_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: a completion pulse only follows an active cycle and leaves it idle
  p_done_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R10: the wait count never drops inside a cycle
  p_wait_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (wait_cnt >= $past(wait_cnt)));
endmodule

// File: rtl/bus_cycle_adapter.sv
module bus_cycle_adapter
  import bca_pkg::*;
#(
  parameter int WAIT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_n,
  input  logic              rdy_n,
  input  logic [29:0]       word_addr,
  input  logic [3:0]        lane_en_n,
  input  logic              mem_sel,
  output logic [31:0]       phys_addr,
  output logic [3:0]        lane_mask,
  output logic              no_lane_err,
  output logic              is_mem,
  output logic              pio_hit,
  output logic              cop_cs,
  output logic              io_range_err,
  output logic              busy,
  output logic              cyc_done,
  output logic [WAIT_W-1:0] wait_cnt
);
  localparam int LANES  = 4;
  localparam int ADDR_W = 32;
  localparam int LOW_W  = $clog2(LANES);

  logic [LANES-1:0] mask_d;
  logic [LOW_W-1:0] low_d;
  logic             none_d;
  space_t           sp_d;
  logic             start;

  lane_decode #(.LANES(LANES)) u_lane (
    .en_n(lane_en_n), .mask(mask_d), .low(low_d), .none(none_d)
  );

  space_decode #(.ADDR_W(ADDR_W), .PIO_W(16)) u_space (
    .wa(word_addr), .mem(mem_sel), .sp(sp_d)
  );

  cycle_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .strb_n(strb_n), .rdy_n(rdy_n),
    .start(start), .busy(busy), .done(cyc_done), .wait_cnt(wait_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phys_addr    <= '0;
      lane_mask    <= '0;
      no_lane_err  <= 1'b0;
      is_mem       <= 1'b0;
      pio_hit      <= 1'b0;
      cop_cs       <= 1'b0;
      io_range_err <= 1'b0;
    end else if (start) begin
      phys_addr    <= {word_addr, low_d};
      lane_mask    <= mask_d;
      no_lane_err  <= none_d;
      is_mem       <= mem_sel;
      pio_hit      <= sp_d.pio;
      cop_cs       <= sp_d.cop;
      io_range_err <= sp_d.oor;
    end
  end

  // R8: captured outputs hold for the whole active cycle
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(phys_addr) && $stable(lane_mask) && $stable(cop_cs)));
  // R7: at most one space flag at a time
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pio_hit, cop_cs, io_range_err}));
  // R7: memory cycles carry no I/O flags
  p_mem_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_mem |-> !(pio_hit || cop_cs || io_range_err));
  // R3: an empty lane set leaves the low bits at zero
  p_empty_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    no_lane_err |-> (phys_addr[1:0] == 2'b00 && lane_mask == 4'b0000));
endmodule

// File: tb/sim_bus_cycle_adapter.sv
module sim_bus_cycle_adapter;
  localparam int WW = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strb_n = 1'b1, rdy_n = 1'b1, mem_sel = 1'b1;
  logic [29:0] word_addr = '0;
  logic [3:0] lane_en_n = 4'hF;
  logic [31:0] phys_addr;
  logic [3:0] lane_mask;
  logic no_lane_err, is_mem, pio_hit, cop_cs, io_range_err, busy, cyc_done;
  logic [WW-1:0] wait_cnt;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  bus_cycle_adapter #(.WAIT_W(WW)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_low(input logic [3:0] be);
    if (!be[0]) return 2'd0;
    if (!be[1]) return 2'd1;
    if (!be[2]) return 2'd2;
    if (!be[3]) return 2'd3;
    return 2'd0;
  endfunction

  task automatic check_outs(input logic [31:0] a, input logic [3:0] be, input logic mem);
    logic [31:0] ea = {a[31:2], exp_low(be)};
    logic ep = !mem && (a[31:16] == 0);
    logic ec = !mem && a[31];
    chk(phys_addr[31:2] == ea[31:2], "R4 upper addr", phys_addr, ea);
    chk(phys_addr[1:0] == ea[1:0], "R2 low bits", phys_addr, ea);
    chk(lane_mask == ~be, "R1 lane mask", lane_mask, ~be);
    chk(no_lane_err == (be == 4'hF), "R3 no-lane flag", no_lane_err, be == 4'hF);
    chk(is_mem == mem, "R7 is_mem", is_mem, mem);
    chk(pio_hit == ep, "R5 pio_hit", pio_hit, ep);
    chk(cop_cs == ec, "R6 cop_cs", cop_cs, ec);
    chk(io_range_err == (!mem && !ep && !ec), "R7 range err", io_range_err, !mem && !ep && !ec);
  endtask

  // one full cycle; disturb = change inputs and strobe again mid-cycle
  task automatic run_cycle(input logic [31:0] a, input logic [3:0] be, input logic mem,
                           input int nwait, input bit disturb);
    int ew = (nwait > 7) ? 7 : nwait;
    @(negedge clk);
    strb_n = 1'b0; word_addr = a[31:2]; lane_en_n = be; mem_sel = mem;
    rdy_n = 1'b0;  // R9: ready at strobe edge must be ignored
    @(negedge clk);
    chk(busy == 1'b1, "R8 busy after strobe", busy, 1);
    check_outs(a, be, mem);
    strb_n = disturb ? 1'b0 : 1'b1;
    if (disturb) begin word_addr = ~word_addr; lane_en_n = ~be; mem_sel = ~mem; end
    for (int k = 0; k < nwait; k++) begin
      rdy_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b1 && cyc_done == 1'b0, "R9 still busy in wait", busy, 1);
    end
    if (disturb) check_outs(a, be, mem);  // R8 hold
    rdy_n = 1'b0;
    @(negedge clk);
    strb_n = 1'b1; rdy_n = 1'b1;
    chk(cyc_done == 1'b1 && busy == 1'b0, "R9 end pulse", {cyc_done, busy}, 2'b10);
    chk(wait_cnt == WW'(ew), "R10 wait count", wait_cnt, ew);
    @(negedge clk);
    chk(cyc_done == 1'b0, "R9 pulse one clock", cyc_done, 0);
    chk(wait_cnt == WW'(ew), "R10 wait held", wait_cnt, ew);
    check_outs(a, be, mem);
  endtask

  task automatic t_reset();
    chk(busy == 0 && cyc_done == 0, "R9 reset idle", busy, 0);
    chk(phys_addr == 0 && wait_cnt == 0, "R8 reset outputs", phys_addr, 0);
  endtask

  task automatic t_lanes();  // R1 R2 R3
    for (int b = 0; b < 16; b++) run_cycle(32'h1234_5678 + (b << 2), 4'(b), 1'b1, 0, 1'b0);
  endtask

  task automatic t_space();  // R5 R6 R7
    run_cycle(32'h0000_FFFC, 4'h0, 1'b0, 1, 1'b0);
    run_cycle(32'h0001_0000, 4'hE, 1'b0, 0, 1'b0);
    run_cycle(32'h8000_00F8, 4'h7, 1'b0, 2, 1'b0);
    run_cycle(32'h8000_00FC, 4'h3, 1'b0, 0, 1'b0);
    run_cycle(32'h7FFF_FFFC, 4'hD, 1'b0, 0, 1'b0);
    run_cycle(32'hFFFF_FFF0, 4'h0, 1'b1, 0, 1'b0);
    run_cycle(32'h0000_0000, 4'hF, 1'b0, 0, 1'b0);
  endtask

  task automatic t_waits();  // R9 R10
    run_cycle(32'h0000_1000, 4'h0, 1'b1, 3, 1'b0);
    run_cycle(32'h0000_2000, 4'h0, 1'b1, 7, 1'b0);
    run_cycle(32'h0000_3000, 4'h0, 1'b1, 11, 1'b0);
  endtask

  task automatic t_hold();  // R8
    run_cycle(32'h8000_00F8, 4'hB, 1'b0, 2, 1'b1);
    run_cycle(32'h0000_0040, 4'h8, 1'b1, 0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lanes();
    t_space();
    t_waits();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule